// File: doc/BRIEF.md
# Audio Bit and Frame Clock Divider

This block turns a master audio clock into the two timing clocks of a serial audio link. The bit clock is the master clock divided by 2 or 4, as a one-bit select picks. The frame clock, which marks the left and right halves of each sample period, is built by counting bit-clock periods. A frame lasts 32, 64 or 128 bit clocks, as a three-bit select field picks. Both outputs come from registers clocked by the master clock. The frame clock can change only in the master cycle in which the bit clock falls, so it stays in step with the bit clock.

One enable controls the whole chain. While it is low, both clocks are held low and both counters are cleared. The next enable therefore starts a fresh frame in its low (left) half. The frame select has three legal codes. Any other code holds the frame clock low and raises an error flag. The bit clock keeps running in that case, so a bad frame setting can be told apart from a disabled chain.

Top module: `aud_sclk_chain`

## Requirements
- R1: While reset is asserted, `bclk_o`, `lrclk_o` and `frame_sel_err_o` are all 0.
- R2: With `bclk_div_sel` = 0 and the chain enabled, `bclk_o` is 1 from the first master edge after enable and toggles on every master edge (divide by 2).
- R3: With `bclk_div_sel` = 1 and the chain enabled, `bclk_o` is 0 after the first master edge, then toggles every second master edge (divide by 4).
- R4: Frame select code 0, 1 or 2 gives a frame of 32, 64 or 128 bit-clock periods, with `lrclk_o` low for the first half and high for the second half.
- R5: While enabled with a legal code, `lrclk_o` changes only on a master edge where `bclk_o` goes from 1 to 0.
- R6: The frame length is counted in bit-clock periods, so in master cycles it doubles when `bclk_div_sel` moves from 0 to 1.
- R7: A frame select code from 3 to 7 holds `lrclk_o` at 0 and sets `frame_sel_err_o` to 1 one master edge later. `bclk_o` keeps running.
- R8: On the first master edge with `enable` low, `bclk_o` and `lrclk_o` go to 0. A later enable restarts both dividers from count zero, with `lrclk_o` low.
- R9: `frame_sel_err_o` is 0 one master edge after a legal frame select code is applied, whether the chain is enabled or not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master audio clock. All registers run on it |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs both dividers when high. Clears and silences them when low |
| bclk_div_sel | input | 1 | Bit-clock divide select: 0 divides by 2, 1 divides by 4 |
| frame_sel | input | 3 | Frame length code: 0 = 32, 1 = 64, 2 = 128 bit clocks. 3 to 7 are illegal |
| bclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Frame (left/right) clock, 50% duty |
| frame_sel_err_o | output | 1 | High while the frame select code is illegal |

## Verification
The frame-edge property assumes that both select inputs stay unchanged while `enable` is high. A select change in the middle of a run could leave a counter above its new terminal count and shift the phase. The bench therefore changes selects only after at least one master edge with `enable` low, and it changes every input on the falling master edge. The bench's model derives the expected clock levels from the number of master edges since enable. It never uses the design's counters, so a wrong terminal count or a wrong edge choice shows up as a level mismatch.

// File: rtl/aud_clk_pkg.sv
package aud_clk_pkg;

    // Default divider geometry. The modules take these through parameters.
    localparam int unsigned BCLK_DIV_LO_DEF  = 2;
    localparam int unsigned BCLK_DIV_HI_DEF  = 4;
    localparam int unsigned FRAME_BASE_DEF   = 32;
    localparam int unsigned FRAME_CODES_DEF  = 3;
    localparam int unsigned FSEL_W_DEF       = 3;

    // Half-frame length in bit clocks for a legal code.
    function automatic int unsigned half_frame_len(int unsigned base, int unsigned code);
        return (base / 2) << code;
    endfunction

endpackage

// File: rtl/aud_bclk_gen.sv
module aud_bclk_gen #(
    parameter int unsigned DIV_LO = 2,
    parameter int unsigned DIV_HI = 4,
    parameter int unsigned CNT_W  = $clog2(DIV_HI / 2) + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sel,
    output logic bclk_o,
    output logic fall_stb_o
);
    localparam logic [CNT_W-1:0] LAST_LO = CNT_W'(DIV_LO / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_HI = CNT_W'(DIV_HI / 2 - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             bclk;
    } bstate_t;

    bstate_t st_d, st_q;
    logic    last;

    always_comb begin
        st_d = st_q;
        last = (st_q.cnt >= (sel ? LAST_HI : LAST_LO));
        if (!en) begin
            st_d.cnt  = '0;
            st_d.bclk = 1'b0;
        end else if (last) begin
            st_d.cnt  = '0;
            st_d.bclk = ~st_q.bclk;
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bclk_o     = st_q.bclk;
    // High in the cycle whose closing edge drives the bit clock low.
    assign fall_stb_o = en && last && st_q.bclk;

endmodule

// File: rtl/aud_lr_gen.sv
module aud_lr_gen
    import aud_clk_pkg::*;
#(
    parameter int unsigned FSEL_W      = 3,
    parameter int unsigned FRAME_BASE  = 32,
    parameter int unsigned FRAME_CODES = 3,
    parameter int unsigned CNT_W       = $clog2(half_frame_len(FRAME_BASE, FRAME_CODES - 1))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              fall_stb,
    input  logic [FSEL_W-1:0] fsel,
    output logic              lrclk_o,
    output logic              err_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             lr;
        logic             err;
    } lstate_t;

    lstate_t          st_d, st_q;
    logic             legal;
    logic [CNT_W-1:0] term;

    always_comb begin
        legal = 1'b0;
        term  = '0;
        for (int i = 0; i < FRAME_CODES; i++) begin
            if (fsel == FSEL_W'(i)) begin
                legal = 1'b1;
                term  = CNT_W'(half_frame_len(FRAME_BASE, i) - 1);
            end
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.err = ~legal;
        if (!en || !legal) begin
            st_d.cnt = '0;
            st_d.lr  = 1'b0;
        end else if (fall_stb) begin
            if (st_q.cnt >= term) begin
                st_d.cnt = '0;
                st_d.lr  = ~st_q.lr;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lrclk_o = st_q.lr;
    assign err_o   = st_q.err;

endmodule

// File: rtl/aud_sclk_chain.sv
module aud_sclk_chain
    import aud_clk_pkg::*;
#(
    parameter int unsigned BCLK_DIV_LO = BCLK_DIV_LO_DEF,
    parameter int unsigned BCLK_DIV_HI = BCLK_DIV_HI_DEF,
    parameter int unsigned FRAME_BASE  = FRAME_BASE_DEF,
    parameter int unsigned FRAME_CODES = FRAME_CODES_DEF,
    parameter int unsigned FSEL_W      = FSEL_W_DEF
) (
    input  logic              mclk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              bclk_div_sel,
    input  logic [FSEL_W-1:0] frame_sel,
    output logic              bclk_o,
    output logic              lrclk_o,
    output logic              frame_sel_err_o
);
    localparam int unsigned BCNT_W = $clog2(BCLK_DIV_HI / 2) + 1;
    localparam int unsigned FCNT_W = $clog2(half_frame_len(FRAME_BASE, FRAME_CODES - 1));

    logic bclk_fall;

    aud_bclk_gen #(
        .DIV_LO (BCLK_DIV_LO),
        .DIV_HI (BCLK_DIV_HI),
        .CNT_W  (BCNT_W)
    ) u_bclk (
        .clk        (mclk),
        .rst_n      (rst_n),
        .en         (enable),
        .sel        (bclk_div_sel),
        .bclk_o     (bclk_o),
        .fall_stb_o (bclk_fall)
    );

    aud_lr_gen #(
        .FSEL_W      (FSEL_W),
        .FRAME_BASE  (FRAME_BASE),
        .FRAME_CODES (FRAME_CODES),
        .CNT_W       (FCNT_W)
    ) u_lr (
        .clk      (mclk),
        .rst_n    (rst_n),
        .en       (enable),
        .fall_stb (bclk_fall),
        .fsel     (frame_sel),
        .lrclk_o  (lrclk_o),
        .err_o    (frame_sel_err_o)
    );

endmodule

// File: rtl/aud_sclk_chain_chk.sv
module aud_sclk_chain_chk #(
    parameter int unsigned FSEL_W      = 3,
    parameter int unsigned FRAME_CODES = 3
) (
    input logic              mclk,
    input logic              rst_n,
    input logic              enable,
    input logic              bclk_div_sel,
    input logic [FSEL_W-1:0] frame_sel,
    input logic              bclk_o,
    input logic              lrclk_o,
    input logic              frame_sel_err_o
);
    // R2
    bclk_div2_toggle_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        (enable && !bclk_div_sel) |=> (bclk_o != $past(bclk_o)));

    // R5
    lr_on_bclk_fall_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        ($past(enable) && !frame_sel_err_o && (lrclk_o != $past(lrclk_o)))
        |-> ($past(bclk_o) && !bclk_o));

    // R7
    illegal_holds_lr_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        frame_sel_err_o |-> !lrclk_o);

    // R7
    illegal_flags_err_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        (frame_sel >= FSEL_W'(FRAME_CODES)) |=> frame_sel_err_o);

    // R8
    disable_quiet_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        !enable |=> (!bclk_o && !lrclk_o));

    // R9
    legal_clears_err_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        (frame_sel < FSEL_W'(FRAME_CODES)) |=> !frame_sel_err_o);

endmodule

bind aud_sclk_chain aud_sclk_chain_chk #(
    .FSEL_W      (FSEL_W),
    .FRAME_CODES (FRAME_CODES)
) chk_i (
    .mclk            (mclk),
    .rst_n           (rst_n),
    .enable          (enable),
    .bclk_div_sel    (bclk_div_sel),
    .frame_sel       (frame_sel),
    .bclk_o          (bclk_o),
    .lrclk_o         (lrclk_o),
    .frame_sel_err_o (frame_sel_err_o)
);

// File: tb/aud_sclk_chain_tb_top.sv
`timescale 1ns/1ps
module aud_sclk_chain_tb_top;

    logic       mclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       bclk_div_sel = 1'b0;
    logic [2:0] frame_sel = 3'd0;
    logic       bclk_o, lrclk_o, frame_sel_err_o;

    int checks = 0;
    int errors = 0;
    int t_en   = 0;
    bit done   = 1'b0;

    typedef struct {
        logic  bclk;
        logic  lr;
        logic  err;
        logic  lr_edge;
        string tb;
        string tl;
        string te;
    } exp_t;

    exp_t exp_q[$];

    always #2.5 mclk = ~mclk;

    aud_sclk_chain dut_i (
        .mclk            (mclk),
        .rst_n           (rst_n),
        .enable          (enable),
        .bclk_div_sel    (bclk_div_sel),
        .frame_sel       (frame_sel),
        .bclk_o          (bclk_o),
        .lrclk_o         (lrclk_o),
        .frame_sel_err_o (frame_sel_err_o)
    );

    task automatic check(string req, logic act, logic expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, expv, $time);
        end
    endtask

    // Driver: apply a setting, then push one expected item per master edge.
    task automatic run_seg(bit en, bit bsel, int fsel, int ncyc);
        int  half;
        int  hf;
        bit  legal;
        exp_t e;
        logic prev_lr;
        @(negedge mclk);
        enable       = en;
        bclk_div_sel = bsel;
        frame_sel    = 3'(fsel);
        half  = bsel ? 2 : 1;
        legal = (fsel < 3);
        hf    = 16 << (legal ? fsel : 0);
        prev_lr = 1'b0;
        for (int n = 0; n < ncyc; n++) begin
            @(posedge mclk);
            e.err = !legal;
            e.te  = legal ? "R9" : "R7";
            if (!en) begin
                t_en   = 0;
                e.bclk = 1'b0;
                e.lr   = 1'b0;
                e.tb   = "R8";
                e.tl   = "R8";
            end else begin
                t_en++;
                e.bclk = 1'((t_en / half) % 2);
                e.lr   = legal ? 1'((t_en / (2 * half * hf)) % 2) : 1'b0;
                e.tb   = bsel ? "R3" : "R2";
                e.tl   = !legal ? "R7" : (bsel ? "R6" : "R4");
            end
            e.lr_edge = en && legal && (e.lr != prev_lr) && (t_en > 1);
            prev_lr = e.lr;
            exp_q.push_back(e);
        end
    endtask

    // Monitor: compare at the falling edge, away from the update edge.
    logic mon_prev_bclk = 1'b0;
    always @(negedge mclk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tb, bclk_o, e.bclk);
            check(e.tl, lrclk_o, e.lr);
            check(e.te, frame_sel_err_o, e.err);
            if (e.lr_edge) begin
                // R5: frame edge coincides with a bit-clock fall
                check("R5", {mon_prev_bclk, bclk_o} == 2'b10, 1'b1);
            end
        end
        mon_prev_bclk = bclk_o;
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        enable = 1'b1;          // ignored while in reset
        frame_sel = 3'd5;
        repeat (3) @(posedge mclk);
        @(negedge mclk);
        check("R1", bclk_o, 1'b0);
        check("R1", lrclk_o, 1'b0);
        check("R1", frame_sel_err_o, 1'b0);
        enable = 1'b0;
        frame_sel = 3'd0;
        rst_n = 1'b1;

        run_seg(0, 0, 0, 3);
        run_seg(1, 0, 0, 200);   // R2, R4: 32 bit clocks per frame
        run_seg(0, 0, 0, 3);     // R8
        run_seg(1, 1, 0, 300);   // R3, R6
        run_seg(0, 1, 0, 2);
        run_seg(1, 0, 1, 300);   // R4: 64
        run_seg(0, 0, 1, 2);
        run_seg(1, 1, 2, 1100);  // R4, R6: 128
        run_seg(0, 1, 2, 1);     // R8: single disabled edge
        run_seg(1, 1, 0, 150);   // R8 restart low
        run_seg(0, 0, 5, 2);     // R7 while disabled
        run_seg(1, 0, 5, 100);   // R7: bclk runs, lr low
        run_seg(0, 1, 3, 2);
        run_seg(1, 1, 3, 60);
        run_seg(0, 0, 7, 2);
        run_seg(1, 0, 7, 40);
        run_seg(0, 0, 1, 2);     // R9
        run_seg(1, 0, 1, 150);
        @(negedge mclk);
        @(negedge mclk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule